// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write cycles that a host issues to a dual-bank NOR flash and turns the recognised command sequences into single-cycle requests for a separate operation engine. Each write arrives as a one-cycle strobe with a 19-bit word address and a 16-bit data word. Most commands open with a two-write unlock prefix. The decoder then recognises program, whole-chip erase, multi-sector erase, identification entry, read reset and a fast mode that programs without the prefix. It also passes erase suspend and erase resume through while the engine is working.

The decoder also holds the current read mode. In identification mode a combinational read port returns the manufacturer code, the device code or the protection bit of a sector, chosen by three address bits. The engine reports `eng_busy` while it programs or erases and `eng_suspended` while an erase is held. When a sequence is malformed or broken off, the decoder returns to idle and raises no request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all request outputs are low, `ident_mode` is 0 and `ident_data` is 0.
- R2: An unlock pair is AAh written to word address 555h followed by 55h written to 2AAh. Only address bits 10..0 and data bits 7..0 are compared, so upper address bits have no effect. If either write of the pair mismatches, the decoder returns to idle and raises no request.
- R3: After the unlock pair, A0h written to 555h arms a program. The next write raises `req_program` for exactly one cycle, starting on the cycle after that write, with its address and its full data word on `req_addr` and `req_data`. At most one request output is high in any cycle.
- R4: The sequence unlock, 80h to 555h, unlock, 10h to 555h raises `req_chip_erase` for one cycle.
- R5: The sequence unlock, 80h to 555h, unlock, 30h to any address opens a sector-collection window. Every further 30h write adds its sector and restarts the window. After WINDOW cycles with no write, `req_sector_erase` pulses once with a nonzero `req_sector_mask`, where bit n selects sector n. In the default top-boot layout, word addresses below 70000h map to sector addr[18:15]. Above that: 70000h to 71FFFh is 14, 72000h to 75FFFh is 15, 76000h to 76FFFh is 16, 77000h to 77FFFh is 17, 78000h to 78FFFh is 18, 79000h to 79FFFh is 19, 7A000h to 7DFFFh is 20, and 7E000h to 7FFFFh is 21.
- R6: Any write other than 30h inside the sector window cancels the erase, and no erase request follows.
- R7: F0h written to any address raises `req_read_reset` and restores array read mode (`ident_mode` = 0, `ident_data` = 0). This holds in every state except the armed program data cycle and fast mode. The same applies when F0h follows the unlock pair.
- R8: Unlock followed by 90h to 555h sets `ident_mode` to 1. While it is set, a read address whose bits 6,1,0 are 000 returns 0004h and one with 001 returns 224Ah (22CBh for the bottom-boot variant). Other selections return 0.
- R9: In identification mode, read selection 010 returns 0001h if the `prot_bits` bit of the read address's sector is set, and 0000h otherwise.
- R10: B0h written while `eng_busy` is high raises `req_suspend`. When not busy, 30h written from idle while `eng_suspended` is high raises `req_resume`. In both cases the write address appears on `req_addr`.
- R11: While `eng_busy` is high, every write other than B0h and F0h is ignored. The state does not change and no request follows.
- R12: Unlock followed by 20h to 555h enters fast mode. In fast mode, A0h followed by a data write raises `req_program` without any unlock, and a lone F0h is ignored. The pair 90h then F0h leaves fast mode with `req_read_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 19 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| eng_busy | input | 1 | Engine is programming or erasing |
| eng_suspended | input | 1 | Engine holds a suspended erase |
| rd_addr | input | 19 | Read address for identification data |
| prot_bits | input | 22 | Per-sector protection status |
| req_read_reset | output | 1 | Read-reset request pulse |
| req_program | output | 1 | Program request pulse |
| req_chip_erase | output | 1 | Whole-chip erase request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_addr | output | 19 | Address of the last program, suspend or resume request |
| req_data | output | 16 | Data of the last program request |
| req_sector_mask | output | 22 | Sectors selected by the last sector erase request |
| ident_mode | output | 1 | 1 while identification read mode is active |
| ident_data | output | 16 | Identification or protection read data |

## Verification
The assertions assume that `wr_en` is a clean one-cycle-per-write strobe and that `eng_busy` reflects work the engine has started. In particular, `eng_busy` never rises in the same cycle as an erase collection window, so a busy-time suspend cannot coincide with a window commit. The stimulus raises `eng_busy` only while the decoder sits idle, raises `eng_suspended` only while `eng_busy` is low, and spaces every sector-erase write inside the window. Within those limits, the behavioural model in the bench follows each write to the cycle, and the request, mode and read outputs are compared on every clock.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERA1, S_ERA2, S_ERA3,
    S_SWIN, S_FAST, S_FPRG, S_FEXIT
  } seq_state_t;

  typedef enum logic {RD_ARRAY = 1'b0, RD_IDENT = 1'b1} rd_mode_t;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [7:0]  OP_KEY_A   = 8'hAA;
  localparam logic [7:0]  OP_KEY_B   = 8'h55;
  localparam logic [7:0]  OP_PROG    = 8'hA0;
  localparam logic [7:0]  OP_ERASE   = 8'h80;
  localparam logic [7:0]  OP_CHIP    = 8'h10;
  localparam logic [7:0]  OP_SECT    = 8'h30;
  localparam logic [7:0]  OP_IDENT   = 8'h90;
  localparam logic [7:0]  OP_FAST    = 8'h20;
  localparam logic [7:0]  OP_RESET   = 8'hF0;
  localparam logic [7:0]  OP_SUSP    = 8'hB0;
endpackage

// File: rtl/fcd_sector_map.sv
module fcd_sector_map #(
  parameter int SECT_W      = 5,
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  logic [6:0]        sect_bits,
  output logic [SECT_W-1:0] sect
);
  logic [3:0] blk;
  logic [2:0] sub;
  assign blk = sect_bits[6:3];
  assign sub = sect_bits[2:0];

  generate
    if (BOTTOM_BOOT) begin : g_bottom
      always_comb begin
        if (blk >= 4'd2)      sect = SECT_W'(blk) + SECT_W'(6);
        else if (blk == 4'd1) begin
          case (sub)
            3'd0:       sect = SECT_W'(4);
            3'd1:       sect = SECT_W'(5);
            3'd6, 3'd7: sect = SECT_W'(7);
            default:    sect = SECT_W'(6);
          endcase
        end else begin
          case (sub)
            3'd0, 3'd1: sect = SECT_W'(0);
            3'd6:       sect = SECT_W'(2);
            3'd7:       sect = SECT_W'(3);
            default:    sect = SECT_W'(1);
          endcase
        end
      end
    end else begin : g_top
      always_comb begin
        if (blk < 4'd14)       sect = SECT_W'(blk);
        else if (blk == 4'd14) begin
          case (sub)
            3'd0, 3'd1: sect = SECT_W'(14);
            3'd6:       sect = SECT_W'(16);
            3'd7:       sect = SECT_W'(17);
            default:    sect = SECT_W'(15);
          endcase
        end else begin
          case (sub)
            3'd0:       sect = SECT_W'(18);
            3'd1:       sect = SECT_W'(19);
            3'd6, 3'd7: sect = SECT_W'(21);
            default:    sect = SECT_W'(20);
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read
  import fcd_pkg::*;
#(
  parameter int          ADDR_W      = 19,
  parameter int          NUM_SECT    = 22,
  parameter int          SECT_W      = 5,
  parameter bit          BOTTOM_BOOT = 1'b0,
  parameter logic [15:0] MFR_CODE    = 16'h0004,
  parameter logic [15:0] DEV_CODE    = 16'h224A
) (
  input  rd_mode_t            mode,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_SECT-1:0] prot_bits,
  output logic [15:0]         id_data
);
  logic [SECT_W-1:0] rd_sect;
  logic [2:0]        sel;
  logic              unused_rd_bits;

  assign sel            = {rd_addr[6], rd_addr[1], rd_addr[0]};
  assign unused_rd_bits = ^{rd_addr[ADDR_W-8:7], rd_addr[5:2]};

  fcd_sector_map #(.SECT_W(SECT_W), .BOTTOM_BOOT(BOTTOM_BOOT)) u_rd_map (
    .sect_bits (rd_addr[ADDR_W-1 -: 7]),
    .sect      (rd_sect)
  );

  always_comb begin
    id_data = '0;
    if (mode == RD_IDENT) begin
      case (sel)
        3'b000:  id_data = MFR_CODE;
        3'b001:  id_data = DEV_CODE;
        3'b010:  id_data = {15'd0, prot_bits[rd_sect]};
        default: id_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int NUM_SECT    = 22,
  parameter int SECT_W      = 5,
  parameter int WINDOW      = 16,
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                eng_busy,
  input  logic                eng_suspended,
  output logic                req_read_reset,
  output logic                req_program,
  output logic                req_chip_erase,
  output logic                req_sector_erase,
  output logic                req_suspend,
  output logic                req_resume,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [DATA_W-1:0]   req_data,
  output logic [NUM_SECT-1:0] req_sector_mask,
  output rd_mode_t            rd_mode
);
  localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;

  seq_state_t          st, st_n;
  rd_mode_t            mode_n;
  logic [NUM_SECT-1:0] mask, mask_n;
  logic [CNT_W-1:0]    cnt, cnt_n;
  logic [SECT_W-1:0]   wr_sect;
  logic [7:0]          op;
  logic                ka, kb, in_fast;
  logic                rr_n, pg_n, ce_n, se_n, su_n, re_n;
  logic                ld_addr, ld_data, ld_mask;

  assign op      = wr_data[7:0];
  assign ka      = (wr_addr[10:0] == KEY_ADDR_A);
  assign kb      = (wr_addr[10:0] == KEY_ADDR_B);
  assign in_fast = (st == S_FAST) || (st == S_FPRG) || (st == S_FEXIT);

  fcd_sector_map #(.SECT_W(SECT_W), .BOTTOM_BOOT(BOTTOM_BOOT)) u_wr_map (
    .sect_bits (wr_addr[ADDR_W-1 -: 7]),
    .sect      (wr_sect)
  );

  always_comb begin
    st_n = st; mode_n = rd_mode; mask_n = mask; cnt_n = cnt;
    rr_n = 1'b0; pg_n = 1'b0; ce_n = 1'b0; se_n = 1'b0; su_n = 1'b0; re_n = 1'b0;
    ld_addr = 1'b0; ld_data = 1'b0; ld_mask = 1'b0;
    if (st == S_SWIN && !wr_en) begin
      if (cnt == CNT_W'(WINDOW - 1)) begin
        se_n = 1'b1; ld_mask = 1'b1; st_n = S_IDLE;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end else if (wr_en && eng_busy) begin
      if (op == OP_SUSP) begin
        su_n = 1'b1; ld_addr = 1'b1;
      end else if (op == OP_RESET && !in_fast) begin
        rr_n = 1'b1; st_n = S_IDLE; mode_n = RD_ARRAY;
      end
    end else if (wr_en) begin
      if (op == OP_RESET && st != S_PROG && !in_fast) begin
        rr_n = 1'b1; st_n = S_IDLE; mode_n = RD_ARRAY;
      end else begin
        case (st)
          S_IDLE: begin
            if (op == OP_KEY_A && ka) st_n = S_UNL1;
            else if (op == OP_SECT && eng_suspended) begin
              re_n = 1'b1; ld_addr = 1'b1;
            end
          end
          S_UNL1: st_n = (op == OP_KEY_B && kb) ? S_UNL2 : S_IDLE;
          S_UNL2: begin
            st_n = S_IDLE;
            if (ka) begin
              case (op)
                OP_PROG:  st_n = S_PROG;
                OP_ERASE: st_n = S_ERA1;
                OP_IDENT: mode_n = RD_IDENT;
                OP_FAST:  st_n = S_FAST;
                default:  st_n = S_IDLE;
              endcase
            end
          end
          S_PROG: begin
            pg_n = 1'b1; ld_addr = 1'b1; ld_data = 1'b1; st_n = S_IDLE;
          end
          S_ERA1: st_n = (op == OP_KEY_A && ka) ? S_ERA2 : S_IDLE;
          S_ERA2: st_n = (op == OP_KEY_B && kb) ? S_ERA3 : S_IDLE;
          S_ERA3: begin
            st_n = S_IDLE;
            if (op == OP_CHIP && ka) ce_n = 1'b1;
            else if (op == OP_SECT) begin
              st_n = S_SWIN; mask_n = '0; mask_n[wr_sect] = 1'b1; cnt_n = '0;
            end
          end
          S_SWIN: begin
            if (op == OP_SECT) begin
              mask_n[wr_sect] = 1'b1; cnt_n = '0;
            end else begin
              st_n = S_IDLE;
            end
          end
          S_FAST:  st_n = (op == OP_PROG) ? S_FPRG : ((op == OP_IDENT) ? S_FEXIT : S_FAST);
          S_FPRG: begin
            pg_n = 1'b1; ld_addr = 1'b1; ld_data = 1'b1; st_n = S_FAST;
          end
          S_FEXIT: begin
            if (op == OP_RESET) begin
              rr_n = 1'b1; st_n = S_IDLE; mode_n = RD_ARRAY;
            end else begin
              st_n = S_FAST;
            end
          end
          default: st_n = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rd_mode <= RD_ARRAY; mask <= '0; cnt <= '0;
      req_read_reset <= 1'b0; req_program <= 1'b0; req_chip_erase <= 1'b0;
      req_sector_erase <= 1'b0; req_suspend <= 1'b0; req_resume <= 1'b0;
      req_addr <= '0; req_data <= '0; req_sector_mask <= '0;
    end else begin
      st <= st_n; rd_mode <= mode_n; mask <= mask_n; cnt <= cnt_n;
      req_read_reset <= rr_n; req_program <= pg_n; req_chip_erase <= ce_n;
      req_sector_erase <= se_n; req_suspend <= su_n; req_resume <= re_n;
      if (ld_addr) req_addr <= wr_addr;
      if (ld_data) req_data <= wr_data;
      if (ld_mask) req_sector_mask <= mask;
    end
  end

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && eng_busy && op != OP_SUSP && op != OP_RESET) |=> $stable(st));
  // R3
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_read_reset, req_program, req_chip_erase, req_sector_erase, req_suspend, req_resume}));
  // R3
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_program |=> !req_program);
  // R5
  sect_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_sector_erase |-> (req_sector_mask != '0));
  // R10
  susp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_suspend |-> $past(eng_busy));
  // R7
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_read_reset |-> (rd_mode == RD_ARRAY));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int NUM_SECT    = 22,
  parameter int WINDOW      = 16,
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                eng_busy,
  input  logic                eng_suspended,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_SECT-1:0] prot_bits,
  output logic                req_read_reset,
  output logic                req_program,
  output logic                req_chip_erase,
  output logic                req_sector_erase,
  output logic                req_suspend,
  output logic                req_resume,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [DATA_W-1:0]   req_data,
  output logic [NUM_SECT-1:0] req_sector_mask,
  output logic                ident_mode,
  output logic [15:0]         ident_data
);
  localparam int          SECT_W   = $clog2(NUM_SECT);
  localparam logic [15:0] DEV_CODE = BOTTOM_BOOT ? 16'h22CB : 16'h224A;

  rd_mode_t mode;
  assign ident_mode = (mode == RD_IDENT);

  fcd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT), .SECT_W(SECT_W),
    .WINDOW(WINDOW), .BOTTOM_BOOT(BOTTOM_BOOT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_suspended(eng_suspended),
    .req_read_reset(req_read_reset), .req_program(req_program),
    .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase),
    .req_suspend(req_suspend), .req_resume(req_resume),
    .req_addr(req_addr), .req_data(req_data), .req_sector_mask(req_sector_mask),
    .rd_mode(mode)
  );

  fcd_id_read #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .SECT_W(SECT_W),
    .BOTTOM_BOOT(BOTTOM_BOOT), .MFR_CODE(16'h0004), .DEV_CODE(DEV_CODE)
  ) u_id (
    .mode(mode), .rd_addr(rd_addr), .prot_bits(prot_bits), .id_data(ident_data)
  );
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int CLK_P = 10;
  localparam int WIN   = 8;
  localparam int M_IDLE = 0, M_U1 = 1, M_U2 = 2, M_PRG = 3, M_E1 = 4, M_E2 = 5,
                 M_E3 = 6, M_WIN = 7, M_FAST = 8, M_FPRG = 9, M_FX = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        eng_busy = 1'b0;
  logic        eng_suspended = 1'b0;
  logic [18:0] rd_addr = '0;
  logic [21:0] prot_bits = '0;
  logic        req_read_reset, req_program, req_chip_erase, req_sector_erase;
  logic        req_suspend, req_resume, ident_mode;
  logic [18:0] req_addr;
  logic [15:0] req_data, ident_data;
  logic [21:0] req_sector_mask;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_decoder #(.WINDOW(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_suspended(eng_suspended), .rd_addr(rd_addr),
    .prot_bits(prot_bits), .req_read_reset(req_read_reset), .req_program(req_program),
    .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase),
    .req_suspend(req_suspend), .req_resume(req_resume), .req_addr(req_addr),
    .req_data(req_data), .req_sector_mask(req_sector_mask),
    .ident_mode(ident_mode), .ident_data(ident_data)
  );

  int n_checks = 0, n_fail = 0;
  int n_prog = 0, n_chip = 0, n_sect = 0, n_rr = 0, n_susp = 0, n_res = 0;
  logic [21:0] seen_mask = '0;
  logic [18:0] seen_addr = '0;
  logic [15:0] seen_data = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  int          m_st, m_cnt;
  bit          m_mode;
  logic [21:0] m_mask;
  bit          e_rr, e_pg, e_ce, e_se, e_su, e_re;
  logic [18:0] e_addr;
  logic [15:0] e_data;
  logic [21:0] e_mask;
  logic [7:0]  b;
  bit          ka, kb, fst;

  function automatic int sect_of(input logic [18:0] a);
    if (a < 19'h70000) return int'(a >> 15);
    if (a < 19'h72000) return 14;
    if (a < 19'h76000) return 15;
    if (a < 19'h77000) return 16;
    if (a < 19'h78000) return 17;
    if (a < 19'h79000) return 18;
    if (a < 19'h7A000) return 19;
    if (a < 19'h7E000) return 20;
    return 21;
  endfunction

  function automatic logic [15:0] exp_id(input bit md, input logic [18:0] a, input logic [21:0] p);
    if (!md) return 16'h0;
    if (a[6] == 0 && a[1:0] == 2'b00) return 16'h0004;
    if (a[6] == 0 && a[1:0] == 2'b01) return 16'h224A;
    if (a[6] == 0 && a[1:0] == 2'b10) return {15'd0, p[sect_of(a)]};
    return 16'h0;
  endfunction

  task automatic m_go_reset();
    e_rr = 1; m_st = M_IDLE; m_mode = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_mode = 0; m_mask = '0; m_cnt = 0;
      e_rr = 0; e_pg = 0; e_ce = 0; e_se = 0; e_su = 0; e_re = 0;
      e_addr = '0; e_data = '0; e_mask = '0;
    end else begin
      e_rr = 0; e_pg = 0; e_ce = 0; e_se = 0; e_su = 0; e_re = 0;
      b = wr_data[7:0];
      ka = (wr_addr[10:0] == 11'h555);
      kb = (wr_addr[10:0] == 11'h2AA);
      fst = (m_st == M_FAST) || (m_st == M_FPRG) || (m_st == M_FX);
      if (m_st == M_WIN && !wr_en) begin
        if (m_cnt == WIN - 1) begin e_se = 1; e_mask = m_mask; m_st = M_IDLE; end
        else m_cnt++;
      end else if (wr_en && eng_busy) begin
        if (b == 8'hB0) begin e_su = 1; e_addr = wr_addr; end
        else if (b == 8'hF0 && !fst) m_go_reset();
      end else if (wr_en) begin
        if (b == 8'hF0 && m_st != M_PRG && !fst) m_go_reset();
        else begin
          case (m_st)
            M_IDLE: if (b == 8'hAA && ka) m_st = M_U1;
                    else if (b == 8'h30 && eng_suspended) begin e_re = 1; e_addr = wr_addr; end
            M_U1: m_st = (b == 8'h55 && kb) ? M_U2 : M_IDLE;
            M_U2: begin
              m_st = M_IDLE;
              if (ka && b == 8'hA0) m_st = M_PRG;
              if (ka && b == 8'h80) m_st = M_E1;
              if (ka && b == 8'h90) m_mode = 1;
              if (ka && b == 8'h20) m_st = M_FAST;
            end
            M_PRG: begin e_pg = 1; e_addr = wr_addr; e_data = wr_data; m_st = M_IDLE; end
            M_E1: m_st = (b == 8'hAA && ka) ? M_E2 : M_IDLE;
            M_E2: m_st = (b == 8'h55 && kb) ? M_E3 : M_IDLE;
            M_E3: begin
              m_st = M_IDLE;
              if (b == 8'h10 && ka) e_ce = 1;
              else if (b == 8'h30) begin
                m_st = M_WIN; m_mask = '0; m_mask[sect_of(wr_addr)] = 1'b1; m_cnt = 0;
              end
            end
            M_WIN: if (b == 8'h30) begin m_mask[sect_of(wr_addr)] = 1'b1; m_cnt = 0; end
                   else m_st = M_IDLE;
            M_FAST: if (b == 8'hA0) m_st = M_FPRG; else if (b == 8'h90) m_st = M_FX;
            M_FPRG: begin e_pg = 1; e_addr = wr_addr; e_data = wr_data; m_st = M_FAST; end
            M_FX: if (b == 8'hF0) m_go_reset(); else m_st = M_FAST;
            default: m_st = M_IDLE;
          endcase
        end
      end
    end
  end

  // per-clock comparison and pulse counting, away from both edges
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(req_program == e_pg, "R3/R12 req_program", req_program, e_pg);
      chk(req_chip_erase == e_ce, "R4 req_chip_erase", req_chip_erase, e_ce);
      chk(req_sector_erase == e_se, "R5 req_sector_erase", req_sector_erase, e_se);
      chk(req_read_reset == e_rr, "R7 req_read_reset", req_read_reset, e_rr);
      chk(req_suspend == e_su, "R10 req_suspend", req_suspend, e_su);
      chk(req_resume == e_re, "R10 req_resume", req_resume, e_re);
      chk(ident_mode == m_mode, "R8 ident_mode", ident_mode, m_mode);
      chk(ident_data == exp_id(m_mode, rd_addr, prot_bits), "R8/R9 ident_data",
          ident_data, exp_id(m_mode, rd_addr, prot_bits));
      if (e_pg || e_su || e_re)
        chk(req_addr == e_addr, "R3/R10 req_addr", req_addr, e_addr);
      if (e_pg) chk(req_data == e_data, "R3 req_data", req_data, e_data);
      if (e_se) chk(req_sector_mask == e_mask, "R5 req_sector_mask", req_sector_mask, e_mask);
      if (req_program)      begin n_prog++; seen_addr = req_addr; seen_data = req_data; end
      if (req_chip_erase)   n_chip++;
      if (req_sector_erase) begin n_sect++; seen_mask = req_sector_mask; end
      if (req_read_reset)   n_rr++;
      if (req_suspend)      n_susp++;
      if (req_resume)       n_res++;
    end
  end

  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(19'h00555, 16'h00AA); wr(19'h002AA, 16'h0055);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    #1;
    // R1 reset state
    chk(!req_program && !req_read_reset && !req_chip_erase && !req_sector_erase &&
        !req_suspend && !req_resume, "R1 requests after reset", 0, 0);
    chk(ident_mode == 1'b0, "R1 ident_mode after reset", ident_mode, 0);
    chk(ident_data == 16'h0, "R1 ident_data after reset", ident_data, 0);
    @(negedge clk);

    // R3 program
    unlock(); wr(19'h00555, 16'h00A0); wr(19'h12345, 16'hBEEF); idle(2);
    chk(n_prog == 1, "R3 program count", n_prog, 1);
    chk(seen_data == 16'hBEEF, "R3 program data", seen_data, 16'hBEEF);
    chk(seen_addr == 19'h12345, "R3 program addr", seen_addr, 19'h12345);

    // R2 upper address bits ignored in unlock
    wr(19'h7D555, 16'h00AA); wr(19'h452AA, 16'h0055); wr(19'h33555, 16'h00A0);
    wr(19'h00100, 16'h1234); idle(2);
    chk(n_prog == 2, "R2 upper bits ignored", n_prog, 2);

    // R2 bad unlock address, then bad unlock data
    wr(19'h00555, 16'h00AA); wr(19'h002AB, 16'h0055); wr(19'h00555, 16'h00A0);
    wr(19'h00200, 16'h5678); idle(2);
    wr(19'h00555, 16'h00AB); wr(19'h002AA, 16'h0055); wr(19'h00555, 16'h00A0);
    wr(19'h00200, 16'h5678); idle(2);
    chk(n_prog == 2, "R2 mismatch gives no request", n_prog, 2);

    // R4 chip erase
    unlock(); wr(19'h00555, 16'h0080); unlock(); wr(19'h00555, 16'h0010); idle(2);
    chk(n_chip == 1, "R4 chip erase count", n_chip, 1);

    // R5 multi-sector erase
    unlock(); wr(19'h00555, 16'h0080); unlock();
    wr(19'h08000, 16'h0030); idle(3);
    wr(19'h72000, 16'h0030); idle(WIN - 2);
    wr(19'h7F000, 16'h0030); idle(WIN + 3);
    chk(n_sect == 1, "R5 sector erase count", n_sect, 1);
    chk(seen_mask == 22'h208002, "R5 sector mask", seen_mask, 22'h208002);

    // R6 cancel inside window
    unlock(); wr(19'h00555, 16'h0080); unlock();
    wr(19'h00000, 16'h0030); idle(2); wr(19'h00000, 16'h0055); idle(WIN + 3);
    chk(n_sect == 1, "R6 cancelled erase", n_sect, 1);

    // R7 read reset from a partial sequence and after unlock
    wr(19'h00555, 16'h00AA); wr(19'h12345, 16'h00F0); idle(2);
    chk(n_rr == 1, "R7 reset mid-sequence", n_rr, 1);
    unlock(); wr(19'h00555, 16'h00F0); idle(2);
    chk(n_rr == 2, "R7 reset after unlock", n_rr, 2);

    // R8 identification codes
    unlock(); wr(19'h00555, 16'h0090); idle(1);
    chk(ident_mode == 1'b1, "R8 ident entered", ident_mode, 1);
    rd_addr = 19'h00000; idle(1);
    chk(ident_data == 16'h0004, "R8 maker code", ident_data, 16'h0004);
    rd_addr = 19'h00001; idle(1);
    chk(ident_data == 16'h224A, "R8 device code", ident_data, 16'h224A);

    // R9 protection query
    prot_bits = 22'h100000;
    rd_addr = 19'h7A002; idle(1);
    chk(ident_data == 16'h0001, "R9 protected sector", ident_data, 1);
    rd_addr = 19'h00002; idle(1);
    chk(ident_data == 16'h0000, "R9 unprotected sector", ident_data, 0);
    wr(19'h00000, 16'h00F0); rd_addr = 19'h00000; idle(1);
    chk(ident_data == 16'h0000, "R7 array mode after reset", ident_data, 0);

    // R11 busy ignores, R10 suspend and resume
    eng_busy = 1'b1;
    unlock(); wr(19'h00555, 16'h00A0); wr(19'h00300, 16'h9999); idle(2);
    chk(n_prog == 2, "R11 busy ignores program", n_prog, 2);
    wr(19'h40000, 16'h00B0); idle(2);
    chk(n_susp == 1, "R10 suspend", n_susp, 1);
    eng_busy = 1'b0; eng_suspended = 1'b1; idle(1);
    wr(19'h40000, 16'h0030); idle(2);
    chk(n_res == 1, "R10 resume", n_res, 1);
    eng_suspended = 1'b0; idle(1);

    // R12 fast mode
    unlock(); wr(19'h00555, 16'h0020);
    wr(19'h00300, 16'h00A0); wr(19'h00300, 16'h5A5A);
    wr(19'h00400, 16'h00A0); wr(19'h00400, 16'h1111); idle(2);
    chk(n_prog == 4, "R12 fast programs", n_prog, 4);
    wr(19'h00000, 16'h00F0); idle(2);
    chk(n_rr == 3, "R12 lone reset ignored in fast mode", n_rr, 3);
    wr(19'h00000, 16'h0090); wr(19'h00000, 16'h00F0); idle(2);
    chk(n_rr == 4, "R12 fast mode exit", n_rr, 4);
    wr(19'h00555, 16'h00A0); wr(19'h00500, 16'h2222); idle(2);
    chk(n_prog == 4, "R12 no program after exit", n_prog, 4);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule